// File: doc/BRIEF.md
# Carry-Chained Integer Add/Subtract Unit

This block is the arithmetic part of an integer execution stage. It takes two 32-bit operands and a 3-bit operation code, and it produces the result in the same cycle. It handles six operations: plain add, add with carry, subtract, subtract with carry, reverse subtract and reverse subtract with carry. Every operation goes through a single adder. A subtraction is formed by adding the bitwise inverse of the subtrahend plus a carry-in.

Because subtraction is built this way, the carry flag is the inverse of borrow. It is 1 when the subtraction needed no borrow. The carry-consuming subtract forms use the incoming carry as that "not borrow" value, so no translation is needed.

The negative, zero, carry and overflow flags are held in a register. The register loads on a clock edge only when the caller asks for flags to be set and the operation code is a valid one.

Top module: `addsub_unit`

## Requirements
- R1: Code 000 (add) gives `opA + opB`, and code 001 (add with carry) gives `opA + opB + carryIn`. In both cases the carry flag is bit 32 of the 33-bit sum.
- R2: Code 010 (subtract) gives `opA - opB`. The carry flag is 1 when `opA >= opB` unsigned (no borrow) and 0 otherwise. For example, 0 minus 0 gives 0x00000000 with carry 1, and 0 minus 1 gives 0xFFFFFFFF with carry 0.
- R3: Code 011 (subtract with carry) gives `opA - opB - (1 - carryIn)`. The carry flag is 1 exactly when `opA >= opB + (1 - carryIn)` unsigned.
- R4: Code 100 (reverse subtract) gives `opB - opA`. Code 101 (reverse subtract with carry) gives `opB - opA - (1 - carryIn)`. The carry flag follows the same no-borrow rule as R2 and R3, with the operands swapped.
- R5: After an update, the N flag equals bit 31 of the result, and the Z flag is 1 exactly when the result is zero.
- R6: After an update, the V flag is 1 exactly when the signed (two's complement) value of the operation lies outside the range -2^31 to 2^31-1.
- R7: The flags load on the rising clock edge only while `setFlags` is 1. Otherwise all four flags keep their previous values. The `result` output is combinational and does not depend on `setFlags`.
- R8: Codes 110 and 111 drive `result` to zero and leave all four flags unchanged, even when `setFlags` is 1.
- R9: While `rstN` is low, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 32 | First operand (the minuend for forward subtracts) |
| opB | input | 32 | Second operand (the minuend for reverse subtracts) |
| opCode | input | 3 | Operation select, encoded as in R1 to R4 and R8 |
| carryIn | input | 1 | Incoming carry flag (the not-borrow value for subtracts) |
| setFlags | input | 1 | Allows the flag register to load on this edge |
| result | output | 32 | Combinational 32-bit result |
| flagN | output | 1 | Registered negative flag |
| flagZ | output | 1 | Registered zero flag |
| flagC | output | 1 | Registered carry / not-borrow flag |
| flagV | output | 1 | Registered signed overflow flag |

## Verification
The bench uses a behavioural reference model that works with wide signed and unsigned integers, and compares against it every cycle.

It targets the following corner cases:
- **Borrow edges of the subtract forms.** These are 0 minus 0, 0 minus 1, and equal operands with the carry-in at 0 and at 1. A design that inverted the carry sense, or treated the incoming carry as a borrow, would report the wrong C flag or be off by one.
- **Signed boundaries.** The bench runs 0x7FFFFFFF plus 1 and 0x80000000 minus 1. These expose an overflow term that looks at the raw operands instead of the inverted adder inputs.
- **Reverse forms.** These catch swapped operands.
- **Runs with set-flags low and with the two unused codes.** These show whether the flag register loads when it must not.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'b000,
    OP_ADC  = 3'b001,
    OP_SUB  = 3'b010,
    OP_SBC  = 3'b011,
    OP_RSB  = 3'b100,
    OP_RSC  = 3'b101,
    OP_RSV6 = 3'b110,
    OP_RSV7 = 3'b111
  } opCode_e;

  // Source of the adder carry-in.
  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cinSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    opValid;   // code names a real operation
    logic    swapOps;   // left adder input takes opB, right takes opA
    logic    invRight;  // right adder input is bit-inverted
    cinSel_e cinSel;    // carry-in source
  } dpStrobe_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opCode,
  output dpStrobe_t       strobe
);

  opCode_e opDec;

  always_comb begin
    opDec = opCode_e'(opCode);
    strobe = '{opValid: 1'b1, swapOps: 1'b0, invRight: 1'b0, cinSel: CIN_ZERO};
    unique case (opDec)
      OP_ADD: strobe.cinSel = CIN_ZERO;
      OP_ADC: strobe.cinSel = CIN_FLAG;
      OP_SUB: begin
        strobe.invRight = 1'b1;
        strobe.cinSel   = CIN_ONE;
      end
      OP_SBC: begin
        strobe.invRight = 1'b1;
        strobe.cinSel   = CIN_FLAG;
      end
      OP_RSB: begin
        strobe.swapOps  = 1'b1;
        strobe.invRight = 1'b1;
        strobe.cinSel   = CIN_ONE;
      end
      OP_RSC: begin
        strobe.swapOps  = 1'b1;
        strobe.invRight = 1'b1;
        strobe.cinSel   = CIN_FLAG;
      end
      default: strobe.opValid = 1'b0;
    endcase
  end

  // A swap is only ever used by a reverse subtract, which always inverts.
  AST_SWAP_INVERTS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swapOps |-> strobe.invRight); // R4

  // Operations with an implicit carry-in of 1 must all be subtracts.
  AST_ONE_IS_SUB: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cinSel == CIN_ONE) |-> strobe.invRight); // R2

endmodule

// File: rtl/addsub_dp.sv
module addsub_dp
  import addsub_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              setFlags,
  input  dpStrobe_t         strobe,
  output logic [DATA_W-1:0] resOut,
  output flags_t            flagsQ
);

  localparam int unsigned SUM_W = DATA_W + 1;
  localparam int unsigned MSB   = DATA_W - 1;

  logic [DATA_W-1:0] leftOp;
  logic [DATA_W-1:0] rightRaw;
  logic [DATA_W-1:0] rightOp;
  logic              cinBit;
  logic [SUM_W-1:0]  sumWide;
  logic [DATA_W-1:0] sumRes;
  logic              carryNext;
  logic              ovfNext;
  logic              updEn;
  flags_t            flagsD;

  // Operand steering: one adder serves every form.
  always_comb begin
    leftOp   = strobe.swapOps ? opB : opA;
    rightRaw = strobe.swapOps ? opA : opB;
    rightOp  = strobe.invRight ? ~rightRaw : rightRaw;
  end

  always_comb begin
    unique case (strobe.cinSel)
      CIN_ONE:  cinBit = 1'b1;
      CIN_FLAG: cinBit = carryIn;
      default:  cinBit = 1'b0;
    endcase
  end

  // 33-bit sum; the top bit is the carry (not-borrow for subtracts).
  assign sumWide   = {1'b0, leftOp} + {1'b0, rightOp} + {{DATA_W{1'b0}}, cinBit};
  assign sumRes    = sumWide[DATA_W-1:0];
  assign carryNext = sumWide[DATA_W];
  assign ovfNext   = (leftOp[MSB] == rightOp[MSB]) && (sumRes[MSB] != leftOp[MSB]);

  assign resOut = strobe.opValid ? sumRes : '0;

  assign updEn = setFlags && strobe.opValid;

  always_comb begin
    flagsD.n = sumRes[MSB];
    flagsD.z = (sumRes == '0);
    flagsD.c = carryNext;
    flagsD.v = ovfNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
    end else if (updEn) begin
      flagsQ <= flagsD;
    end
  end

  // Subtracting zero never borrows.
  AST_SUB_ZERO_NOBORROW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.opValid && !strobe.swapOps && strobe.invRight &&
     strobe.cinSel == CIN_ONE && opB == '0) |-> (carryNext && resOut == opA)); // R2

  // Adding zero with no carry-in passes the operand through without a carry.
  AST_ADD_ZERO_NOCARRY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.opValid && !strobe.invRight && strobe.cinSel == CIN_ZERO && opB == '0)
    |-> (!carryNext && resOut == opA)); // R1

  // Adder inputs of opposite sign cannot overflow.
  AST_NO_MIXED_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (leftOp[MSB] != rightOp[MSB]) |-> !ovfNext); // R6

  // Without an update the flags stay put.
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(setFlags && strobe.opValid) |=> $stable(flagsQ)); // R7

  // After an update, N tracks the sign of the previous result.
  AST_N_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (setFlags && strobe.opValid) |=> (flagsQ.n == $past(resOut[MSB]))); // R5

  // After an update, Z tracks a zero previous result.
  AST_Z_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (setFlags && strobe.opValid) |=> (flagsQ.z == ($past(resOut) == '0))); // R5

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [2:0]        opCode,
  input  logic              carryIn,
  input  logic              setFlags,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagV
);

  dpStrobe_t strobe;
  flags_t    flagsQ;

  addsub_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .opCode (opCode),
    .strobe (strobe)
  );

  addsub_dp #(.DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .setFlags (setFlags),
    .strobe   (strobe),
    .resOut   (result),
    .flagsQ   (flagsQ)
  );

  assign flagN = flagsQ.n;
  assign flagZ = flagsQ.z;
  assign flagC = flagsQ.c;
  assign flagV = flagsQ.v;

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (opCode[2:1] == 2'b11) |-> (result == '0)); // R8

  AST_UNUSED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (opCode[2:1] == 2'b11) |=> $stable({flagN, flagZ, flagC, flagV})); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |-> ({flagN, flagZ, flagC, flagV} == 4'b0000)); // R9

endmodule

// File: tb/addsub_unit_tb.sv
module addsub_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [2:0]  opCode = '0;
  logic        carryIn = 1'b0;
  logic        setFlags = 1'b0;
  logic [31:0] result;
  logic        flagN, flagZ, flagC, flagV;

  int checks = 0;
  int errors = 0;

  // Reference flag state.
  logic mN = 0, mZ = 0, mC = 0, mV = 0;

  always #10 clk = ~clk;

  addsub_unit dut_i (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opCode(opCode),
    .carryIn(carryIn), .setFlags(setFlags), .result(result),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV)
  );

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R1";
      3'd2:       return "R2";
      3'd3:       return "R3";
      3'd4, 3'd5: return "R4";
      default:    return "R8";
    endcase
  endfunction

  // Behavioural reference: wide integer arithmetic.
  task automatic refModel(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic ci, output logic [31:0] res, output logic c, output logic v);
    longint ua, ub, sa, sb, bw, wide, sw;
    ua = longint'({32'b0, a});
    ub = longint'({32'b0, b});
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    res = '0; c = 0; v = 0;
    case (op)
      3'd0, 3'd1: begin
        bw = (op == 3'd1) ? longint'(ci) : 0;
        wide = ua + ub + bw;
        sw = sa + sb + bw;
        res = wide[31:0];
        c = wide[32];
        v = (sw > 64'sd2147483647) || (sw < -64'sd2147483648);
      end
      3'd2, 3'd3, 3'd4, 3'd5: begin
        bw = (op == 3'd3 || op == 3'd5) ? (ci ? 0 : 1) : 0;
        if (op >= 3'd4) begin
          wide = ub - ua - bw; c = (ub >= ua + bw); sw = sb - sa - bw;
        end else begin
          wide = ua - ub - bw; c = (ua >= ub + bw); sw = sa - sb - bw;
        end
        res = wide[31:0];
        v = (sw > 64'sd2147483647) || (sw < -64'sd2147483648);
      end
      default: ;
    endcase
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One operation per clock: drive at negedge, check result mid-low, check flags after the edge.
  task automatic step(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic ci, input logic sf);
    logic [31:0] eRes;
    logic eC, eV;
    @(negedge clk);
    opCode = op; opA = a; opB = b; carryIn = ci; setFlags = sf;
    refModel(op, a, b, ci, eRes, eC, eV);
    #3;
    check(reqOf(op), "result", result, eRes);
    @(posedge clk);
    if (sf && op <= 3'd5) begin
      mN = eRes[31]; mZ = (eRes == 0); mC = eC; mV = eV;
    end
    #2;
    if (!sf) check("R7", "flags NZCV held", {28'b0, flagN, flagZ, flagC, flagV}, {28'b0, mN, mZ, mC, mV});
    else if (op > 3'd5) check("R8", "flags NZCV held", {28'b0, flagN, flagZ, flagC, flagV}, {28'b0, mN, mZ, mC, mV});
    else begin
      check("R5", "flags NZ", {30'b0, flagN, flagZ}, {30'b0, mN, mZ});
      check(reqOf(op), "flag C", {31'b0, flagC}, {31'b0, mC});
      check("R6", "flag V", {31'b0, flagV}, {31'b0, mV});
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state
    #35;
    check("R9", "reset flags", {28'b0, flagN, flagZ, flagC, flagV}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    step(3'd2, 32'h0, 32'h0, 1'b0, 1'b1);                 // R2 0-0 -> 0, C=1
    step(3'd2, 32'h0, 32'h1, 1'b0, 1'b1);                 // R2 0-1 -> FFFFFFFF, C=0
    step(3'd0, 32'h7FFFFFFF, 32'h1, 1'b0, 1'b1);          // R1/R6 signed overflow
    step(3'd0, 32'hFFFFFFFF, 32'h1, 1'b0, 1'b1);          // R1 carry out, Z
    step(3'd1, 32'h10, 32'h20, 1'b1, 1'b1);               // R1 adc
    step(3'd2, 32'h80000000, 32'h1, 1'b0, 1'b1);          // R6 sub overflow
    step(3'd3, 32'h5, 32'h5, 1'b1, 1'b1);                 // R3 no borrow in
    step(3'd3, 32'h5, 32'h5, 1'b0, 1'b1);                 // R3 borrow in
    step(3'd4, 32'h3, 32'h10, 1'b0, 1'b1);                // R4 rsb
    step(3'd5, 32'h10, 32'h3, 1'b0, 1'b1);                // R4 rsc borrow
    step(3'd5, 32'h3, 32'h3, 1'b1, 1'b1);                 // R4 rsc equal
    step(3'd0, 32'h1, 32'h1, 1'b0, 1'b0);                 // R7 hold
    step(3'd2, 32'h0, 32'h1, 1'b0, 1'b0);                 // R7 hold
    step(3'd6, 32'h12345678, 32'h1, 1'b1, 1'b1);          // R8
    step(3'd7, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b1);   // R8

    for (int i = 0; i < 400; i++) begin
      step(3'($urandom_range(0, 7)), $urandom, ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 2)) : $urandom,
           1'($urandom), ($urandom_range(0, 4) != 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule